// File: doc/BRIEF.md
# Bus Master Address Tenure Controller with Retry Handling

This block runs the address phase of a bus master on a split-transaction bus where any snooper may force a retry. A local agent hands it one address at a time. The block raises bus request, waits for a grant while the bus is idle, and issues a one-cycle transfer start. It keeps the address driven until the address acknowledge arrives. In the cycle after the acknowledge it releases the address lines and samples the shared retry line. A clean sample reports the tenure as completed. A retry drops the request and tells the data-tenure logic to abort if its tenure has already begun. The block then withdraws for one cycle and competes for the bus again with the same address.

The block also watches the retry line while it is not the address master. A retry from another agent that appears while the block is idle or requesting makes it withdraw its request for exactly one cycle, so that the other agent can finish a copy-back. A saturating counter records how many of the block's own tenures were retried.

Top module: `art_retry_ctrl`

## Requirements
- R1: After reset, `bus_req`, `ts`, `addr_oe`, `done`, `retried` and `abort` are low, `retry_cnt` is 0 and `req_ready` is high.
- R2: A request taken while `req_ready` is high raises `bus_req` in the next cycle. `ts` is high for exactly one cycle: the cycle after `grant` is sampled high with `bus_busy` low. During that cycle `addr_out` shows the accepted address and `bus_req` is low.
- R3: A grant sampled while `bus_busy` is high is ignored. `ts` stays low, `bus_req` stays high, and the transfer starts only after a grant sampled with the bus free.
- R4: `addr_oe` is high from the `ts` cycle through the cycle in which `aack` is sampled high. It is low in the cycle after that.
- R5: In the cycle after `aack`, a low `artry_in` gives a one-cycle `done` pulse with `retried` low. `req_ready` is high again in the following cycle.
- R6: In the cycle after `aack`, a high `artry_in` gives a one-cycle `retried` pulse. `bus_req` is low in that cycle and the next, and high again in the cycle after those two. The next `ts` repeats the same address.
- R7: `abort` is high only in the cycle of a `retried` pulse, and only when `data_started` is high in that cycle. A high `data_started` with no retry never raises `abort`.
- R8: A rising `artry_in` sampled while the block is idle or requesting holds `bus_req` low for exactly the next cycle, then restores it if the request is still pending. A grant seen during that cycle is ignored.
- R9: `retry_cnt` goes up by one for each `retried` pulse, becoming visible the next cycle. It saturates at 2^CNT_W-1. Retries seen while not the address master do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request to run an address tenure |
| req_addr | input | AW | Address for the request |
| req_ready | output | 1 | Block is idle and accepts a request |
| grant | input | 1 | Bus grant from the arbiter |
| bus_busy | input | 1 | Address bus still occupied by another tenure |
| aack | input | 1 | Address acknowledge from the slave |
| artry_in | input | 1 | Shared address retry line, sampled |
| data_started | input | 1 | Data tenure of the current transfer has begun |
| bus_req | output | 1 | Bus request to the arbiter |
| ts | output | 1 | Transfer start, one cycle |
| addr_oe | output | 1 | Drive enable for address-related lines |
| addr_out | output | AW | Address driven onto the bus |
| abort | output | 1 | Abort the data tenure now |
| done | output | 1 | Tenure completed without retry |
| retried | output | 1 | Tenure was retried and will be reissued |
| retry_cnt | output | CNT_W | Saturating count of own retries |

## Verification
Every cycle, the assertions check these rules: `ts` lasts a single cycle, the drive enable holds while the acknowledge is absent and falls after it, `done` and `retried` never occur together, `abort` appears only with a retry, the foreign-retry withdrawal lasts one cycle, and the counter steps by one or holds at its ceiling. Only the bench scenarios can show the values and ordering across a whole tenure. These are the reissued address after a retry, the exact two-cycle request gap, a grant being ignored while the bus is busy or during a withdrawal, the count staying unchanged after foreign retries, and saturation after many retries.

// File: rtl/art_pkg.sv
package art_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_TS   = 3'd2,
        ST_ADDR = 3'd3,
        ST_SAMP = 3'd4,
        ST_BACK = 3'd5
    } art_state_e;

endpackage

// File: rtl/art_sat_counter.sv
module art_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != CMAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CMAX) |=> (cnt_q == CMAX)); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (cnt_q != CMAX)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/art_snoop_backoff.sv
module art_snoop_backoff (
    input  logic clk,
    input  logic rst_n,
    input  logic artry_in,
    input  logic not_master,
    output logic withdraw
);
    typedef struct packed {
        logic prev;
        logic wd;
    } bk_s;

    bk_s bk_d, bk_q;

    always_comb begin
        bk_d      = bk_q;
        bk_d.prev = artry_in;
        bk_d.wd   = artry_in && !bk_q.prev && not_master;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign withdraw = bk_q.wd;

    AST_WD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        withdraw |=> !withdraw); // R8
    AST_WD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        withdraw |-> ($past(artry_in) && $past(not_master))); // R8

endmodule

// File: rtl/art_tenure_fsm.sv
module art_tenure_fsm
    import art_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          grant,
    input  logic          bus_busy,
    input  logic          aack,
    input  logic          artry_in,
    input  logic          data_started,
    input  logic          withdraw,
    output logic          req_ready,
    output logic          bus_req,
    output logic          ts,
    output logic          addr_oe,
    output logic [AW-1:0] addr_out,
    output logic          done,
    output logic          retried,
    output logic          abort,
    output logic          not_master
);
    typedef struct packed {
        art_state_e    st;
        logic [AW-1:0] addr;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    fsm_d.addr = req_addr;
                    fsm_d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (grant && !bus_busy && !withdraw) begin
                    fsm_d.st = ST_TS;
                end
            end
            ST_TS: begin
                fsm_d.st = aack ? ST_SAMP : ST_ADDR;
            end
            ST_ADDR: begin
                if (aack) begin
                    fsm_d.st = ST_SAMP;
                end
            end
            ST_SAMP: begin
                fsm_d.st = artry_in ? ST_BACK : ST_IDLE;
            end
            ST_BACK: begin
                fsm_d.st = ST_REQ;
            end
            default: begin
                fsm_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, addr: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign req_ready  = (fsm_q.st == ST_IDLE);
    assign bus_req    = (fsm_q.st == ST_REQ) && !withdraw;
    assign ts         = (fsm_q.st == ST_TS);
    assign addr_oe    = (fsm_q.st == ST_TS) || (fsm_q.st == ST_ADDR);
    assign addr_out   = fsm_q.addr;
    assign done       = (fsm_q.st == ST_SAMP) && !artry_in;
    assign retried    = (fsm_q.st == ST_SAMP) && artry_in;
    assign abort      = (fsm_q.st == ST_SAMP) && artry_in && data_started;
    assign not_master = (fsm_q.st == ST_IDLE) || (fsm_q.st == ST_REQ);

    AST_TS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ts |=> !ts); // R2
    AST_TS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ts |-> !bus_req); // R2
    AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe && !aack) |=> addr_oe); // R4
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe && aack) |=> !addr_oe); // R4
    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && retried)); // R5
    AST_ABORT_WITH_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> retried); // R7
    AST_OUTCOME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || retried) |=> !(done || retried)); // R5

endmodule

// File: rtl/art_retry_ctrl.sv
module art_retry_ctrl #(
    parameter int AW    = 32,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    output logic             req_ready,
    input  logic             grant,
    input  logic             bus_busy,
    input  logic             aack,
    input  logic             artry_in,
    input  logic             data_started,
    output logic             bus_req,
    output logic             ts,
    output logic             addr_oe,
    output logic [AW-1:0]    addr_out,
    output logic             abort,
    output logic             done,
    output logic             retried,
    output logic [CNT_W-1:0] retry_cnt
);
    logic withdraw;
    logic not_master;

    art_tenure_fsm #(.AW(AW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .grant        (grant),
        .bus_busy     (bus_busy),
        .aack         (aack),
        .artry_in     (artry_in),
        .data_started (data_started),
        .withdraw     (withdraw),
        .req_ready    (req_ready),
        .bus_req      (bus_req),
        .ts           (ts),
        .addr_oe      (addr_oe),
        .addr_out     (addr_out),
        .done         (done),
        .retried      (retried),
        .abort        (abort),
        .not_master   (not_master)
    );

    art_snoop_backoff u_backoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .artry_in   (artry_in),
        .not_master (not_master),
        .withdraw   (withdraw)
    );

    art_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (retried),
        .cnt   (retry_cnt)
    );

    AST_REQ_DROP_ON_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        retried |-> !bus_req); // R6
    AST_REQ_GAP_AFTER_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        retried |=> !bus_req); // R6
    AST_WD_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        withdraw |-> !bus_req); // R8

endmodule

// File: tb/tb_art_retry_ctrl.sv
`timescale 1ns/1ps
module tb_art_retry_ctrl;
    localparam int AW    = 32;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid, grant, bus_busy, aack, artry_in, data_started;
    logic [AW-1:0]    req_addr;
    logic             req_ready, bus_req, ts, addr_oe, abort, done, retried;
    logic [AW-1:0]    addr_out;
    logic [CNT_W-1:0] retry_cnt;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;

    art_retry_ctrl #(.AW(AW), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .grant(grant), .bus_busy(bus_busy), .aack(aack),
        .artry_in(artry_in), .data_started(data_started), .bus_req(bus_req),
        .ts(ts), .addr_oe(addr_oe), .addr_out(addr_out), .abort(abort),
        .done(done), .retried(retried), .retry_cnt(retry_cnt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // advance one clock; inputs change and outputs are read away from the edge
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic clr_inputs();
        req_valid = 0; grant = 0; bus_busy = 0; aack = 0; artry_in = 0; data_started = 0;
        req_addr = '0;
    endtask

    // take a request and run it up to the transfer-start cycle
    task automatic start_to_ts(input logic [AW-1:0] a);
        req_valid = 1; req_addr = a; settle();
        cyc(); req_valid = 0; settle();
        chk("R2 bus_req after accept", bus_req, 1);
        grant = 1; settle();
        cyc(); grant = 0; settle();
        chk("R2 ts in cycle after grant", ts, 1);
        chk("R2 addr_out on ts", addr_out, a);
        chk("R2 bus_req low on ts", bus_req, 0);
    endtask

    // from ts cycle: one wait cycle, then aack, returns in sample cycle
    task automatic ts_to_sample();
        cyc(); settle();
        chk("R2 ts single cycle", ts, 0);
        chk("R4 addr_oe held before aack", addr_oe, 1);
        aack = 1; settle();
        chk("R4 addr_oe in aack cycle", addr_oe, 1);
        cyc(); aack = 0; settle();
        chk("R4 addr_oe low after aack", addr_oe, 0);
    endtask

    task automatic t_normal(input logic [AW-1:0] a);
        start_to_ts(a);
        ts_to_sample();
        artry_in = 0; data_started = 1; settle();
        chk("R5 done pulse", done, 1);
        chk("R5 retried low", retried, 0);
        chk("R7 no abort without retry", abort, 0);
        cyc(); data_started = 0; settle();
        chk("R5 done one cycle", done, 0);
        chk("R5 ready again", req_ready, 1);
    endtask

    task automatic t_retry(input logic [AW-1:0] a, input logic ds);
        start_to_ts(a);
        ts_to_sample();
        artry_in = 1; data_started = ds; settle();
        chk("R6 retried pulse", retried, 1);
        chk("R6 bus_req low in retry cycle", bus_req, 0);
        chk("R7 abort follows data_started", abort, ds);
        chk("R6 no done on retry", done, 0);
        cyc(); artry_in = 0; data_started = 0; settle();
        if (exp_cnt < (1 << CNT_W) - 1) exp_cnt++;
        chk("R6 bus_req low after retry", bus_req, 0);
        chk("R7 abort gone", abort, 0);
        chk("R9 retry count", retry_cnt, exp_cnt);
        cyc(); settle();
        chk("R6 bus_req restored", bus_req, 1);
        grant = 1; settle();
        cyc(); grant = 0; settle();
        chk("R6 reissue ts", ts, 1);
        chk("R6 same address reissued", addr_out, a);
        ts_to_sample();
        artry_in = 0; settle();
        chk("R5 done after reissue", done, 1);
        cyc(); settle();
    endtask

    task automatic t_busy(input logic [AW-1:0] a);
        req_valid = 1; req_addr = a; settle();
        cyc(); req_valid = 0; grant = 1; bus_busy = 1; settle();
        cyc(); settle();
        chk("R3 no ts while busy", ts, 0);
        chk("R3 bus_req kept while busy", bus_req, 1);
        bus_busy = 0; settle();
        cyc(); grant = 0; settle();
        chk("R3 ts once bus free", ts, 1);
        chk("R3 address", addr_out, a);
        ts_to_sample();
        settle();
        chk("R5 done after busy wait", done, 1);
        cyc(); settle();
    endtask

    task automatic t_foreign(input logic [AW-1:0] a);
        req_valid = 1; req_addr = a; settle();
        cyc(); req_valid = 0; settle();
        artry_in = 1; settle();
        chk("R8 bus_req still high in retry cycle", bus_req, 1);
        cyc(); artry_in = 0; grant = 1; settle();
        chk("R8 bus_req withdrawn one cycle", bus_req, 0);
        cyc(); settle();
        chk("R8 grant ignored during withdrawal", ts, 0);
        chk("R8 bus_req restored", bus_req, 1);
        cyc(); grant = 0; settle();
        chk("R8 ts after restore", ts, 1);
        chk("R9 foreign retry not counted", retry_cnt, exp_cnt);
        ts_to_sample();
        settle();
        chk("R5 done after foreign retry", done, 1);
        cyc(); settle();
    endtask

    task automatic t_saturate();
        for (int i = 0; i < (1 << CNT_W) + 2; i++) begin
            t_retry(32'h4000_0000 + i, 1'b0);
        end
        chk("R9 counter saturated", retry_cnt, (1 << CNT_W) - 1);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #2; rst_n = 1; settle();
        chk("R1 bus_req reset", bus_req, 0);
        chk("R1 ts reset", ts, 0);
        chk("R1 addr_oe reset", addr_oe, 0);
        chk("R1 outcomes reset", {done, retried, abort}, 0);
        chk("R1 count reset", retry_cnt, 0);
        chk("R1 ready reset", req_ready, 1);
        t_normal(32'hA000_0010);
        t_busy(32'hB000_0020);
        t_retry(32'hC000_0030, 1'b1);
        t_retry(32'hD000_0040, 1'b0);
        t_foreign(32'hE000_0050);
        t_saturate();
        t_normal(32'h1234_5678);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule